// File: doc/BRIEF.md
# Predicated Vector Group Select

This block merges two groups of vector registers element by element. One group supplies the values taken where an element is active; the other supplies the values taken where it is not. A group holds either two or four registers of a fixed bit length. The same count applies to the destination group and to both source groups. The element width is chosen per operation by a two-bit code.

Activity comes from one predicate in counter form: an active-element count plus an invert flag. The count spans the whole group, so one count can cover the first register fully and end partway through a later one. Elements are numbered in one flat sequence across the group: element e of register r has flat index r × (elements per register) + e. The merged group is presented one cycle after a valid request, together with a valid strobe.

Top module: `vsel_group`

## Requirements
- R1: `size_code` sets the element width to 8 << code bits: 0 = 8, 1 = 16, 2 = 32, 3 = 64. Each register then holds VLEN / width elements.
- R2: `quad_sel` = 1 selects a group of four registers (register r at bits [r*VLEN +: VLEN]). `quad_sel` = 0 selects two registers, and in that mode output registers 2 and 3 are all zero.
- R3: Each destination element equals the matching `src_a` element when it is active, and the matching `src_b` element otherwise.
- R4: With `pred_invert` = 0, an element is active exactly when its flat index r × (elements per register) + e is below `pred_count`.
- R5: With `pred_invert` = 1, the activity given by R4 is complemented for every element.
- R6: A count of zero makes no element active. A count at or above the number of elements in the group makes every element active.
- R7: `out_valid` is high in the cycle after a cycle with `in_valid` high, and low otherwise. `dst` changes only after a valid request.
- R8: While reset is asserted, `out_valid` is low and `dst` is all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Request strobe |
| size_code | input | 2 | Element width code |
| quad_sel | input | 1 | 1 = four-register group, 0 = two-register group |
| pred_count | input | CNT_W | Active-element count |
| pred_invert | input | 1 | Complements the activity of every element |
| src_a | input | 4*VLEN | Group taken where an element is active |
| src_b | input | 4*VLEN | Group taken where an element is inactive |
| out_valid | output | 1 | Result strobe |
| dst | output | 4*VLEN | Merged destination group |

## Verification
The hardest case to reach from the ports is a count that ends exactly on a register boundary, or one element to either side of it. In that case the flat element numbering decides whether the first element of the next register is taken from the wrong source. The stimulus table pairs every element width with counts placed on those boundaries, in both group sizes and with inversion. In every case the two source groups differ in every byte. Counting how many result elements came from the first source therefore confirms the active count independently of the element-by-element comparison.

// File: rtl/vsel_pkg.sv
package vsel_pkg;

  localparam int unsigned GRP_MAX  = 4;
  localparam int unsigned GRP_PAIR = 2;

  // width of one element in bytes for a given size code
  function automatic logic [31:0] elem_bytes(input logic [1:0] code);
    return 32'd1 << code;
  endfunction

  // flat element number owning a flat byte position
  function automatic logic [31:0] elem_of_byte(input logic [31:0] pos,
                                               input logic [1:0]  code);
    return pos >> code;
  endfunction

  // lowest byte of the element slot holding a byte position
  function automatic logic [31:0] slot_base(input logic [31:0] pos,
                                            input logic [1:0]  code);
    return pos & ~(elem_bytes(code) - 32'd1);
  endfunction

  // counter-form activity test before inversion
  function automatic logic below_count(input logic [31:0] idx,
                                       input logic [31:0] cnt);
    return idx < cnt;
  endfunction

endpackage

// File: rtl/vsel_pred_expand.sv
module vsel_pred_expand
  import vsel_pkg::*;
#(
  parameter int unsigned MASK_W = 64,
  parameter int unsigned CNT_W  = 16
) (
  input  logic [1:0]        size_code,
  input  logic [CNT_W-1:0]  count,
  input  logic              invert,
  output logic [MASK_W-1:0] mask
);

  // one mask bit per byte of the group; every byte of an element
  // gets that element's activity
  for (genvar p = 0; p < MASK_W; p++) begin : g_bit
    logic [31:0] eidx;
    assign eidx    = elem_of_byte(32'(p), size_code);
    assign mask[p] = below_count(eidx, 32'(count)) ^ invert;
  end

endmodule

// File: rtl/vsel_lane_mux.sv
module vsel_lane_mux
  import vsel_pkg::*;
#(
  parameter int unsigned VLEN    = 128,
  parameter int unsigned MASK_W  = 64,
  parameter int unsigned REG_IDX = 0
) (
  input  logic [1:0]        size_code,
  input  logic              in_group,
  input  logic [MASK_W-1:0] mask,
  input  logic [VLEN-1:0]   a_reg,
  input  logic [VLEN-1:0]   b_reg,
  output logic [VLEN-1:0]   y_reg
);

  localparam int unsigned PL     = VLEN / 8;
  localparam int unsigned MIDX_W = $clog2(MASK_W);

  logic [PL-1:0] lane_act;

  for (genvar b = 0; b < PL; b++) begin : g_byte
    logic [31:0] base;
    // only the lowest mask bit of the element slot decides
    assign base        = slot_base(32'(REG_IDX * PL + b), size_code);
    assign lane_act[b] = mask[MIDX_W'(base)];
    assign y_reg[8*b +: 8] = !in_group    ? 8'h00 :
                             lane_act[b]  ? a_reg[8*b +: 8] :
                                            b_reg[8*b +: 8];
  end

endmodule

// File: rtl/vsel_group.sv
module vsel_group
  import vsel_pkg::*;
#(
  parameter int unsigned VLEN  = 128,
  parameter int unsigned CNT_W = 16
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    in_valid,
  input  logic [1:0]              size_code,
  input  logic                    quad_sel,
  input  logic [CNT_W-1:0]        pred_count,
  input  logic                    pred_invert,
  input  logic [GRP_MAX*VLEN-1:0] src_a,
  input  logic [GRP_MAX*VLEN-1:0] src_b,
  output logic                    out_valid,
  output logic [GRP_MAX*VLEN-1:0] dst
);

  localparam int unsigned PL     = VLEN / 8;
  localparam int unsigned MASK_W = PL * GRP_MAX;
  localparam int unsigned GRP_W  = VLEN * GRP_MAX;

  logic [MASK_W-1:0] grp_mask;
  logic [GRP_W-1:0]  merged;
  logic [GRP_W-1:0]  dst_q;
  logic              valid_q;
  logic              quad_q;

  vsel_pred_expand #(
    .MASK_W (MASK_W),
    .CNT_W  (CNT_W)
  ) u_expand (
    .size_code (size_code),
    .count     (pred_count),
    .invert    (pred_invert),
    .mask      (grp_mask)
  );

  for (genvar r = 0; r < GRP_MAX; r++) begin : g_reg
    logic in_group;
    assign in_group = quad_sel || (r < GRP_PAIR);
    vsel_lane_mux #(
      .VLEN    (VLEN),
      .MASK_W  (MASK_W),
      .REG_IDX (r)
    ) u_lane (
      .size_code (size_code),
      .in_group  (in_group),
      .mask      (grp_mask),
      .a_reg     (src_a[r*VLEN +: VLEN]),
      .b_reg     (src_b[r*VLEN +: VLEN]),
      .y_reg     (merged[r*VLEN +: VLEN])
    );
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      quad_q  <= 1'b0;
      dst_q   <= '0;
    end else begin
      valid_q <= in_valid;
      if (in_valid) begin
        quad_q <= quad_sel;
        dst_q  <= merged;
      end
    end
  end

  assign out_valid = valid_q;
  assign dst       = dst_q;

  AST_VALID_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid); // R7
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid); // R7
  AST_HOLD_DST: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(dst)); // R7
  AST_PAIR_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !quad_q) |-> (dst[GRP_W-1:GRP_PAIR*VLEN] == '0)); // R2
  AST_EMPTY_MASK: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && pred_count == '0 && !pred_invert) |-> (grp_mask == '0)); // R6
  AST_FULL_MASK: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && 32'(pred_count) >= MASK_W && !pred_invert) |-> (&grp_mask)); // R6
  AST_INVERT_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && pred_count == '0 && pred_invert) |-> (&grp_mask)); // R5

endmodule

// File: tb/vsel_group_tb.sv
module vsel_group_tb;

  localparam int VLEN = 128;
  localparam int CW   = 16;
  localparam int GW   = 4 * VLEN;
  localparam int NT   = 14;

  // {size, quad, count, invert, expected active elements}
  localparam logic [26:0] TBL [NT] = '{
    {2'd0, 1'b1, 16'd20,  1'b0, 7'd20},
    {2'd0, 1'b0, 16'd16,  1'b0, 7'd16},
    {2'd1, 1'b1, 16'd8,   1'b0, 7'd8 },
    {2'd1, 1'b0, 16'd5,   1'b0, 7'd5 },
    {2'd2, 1'b1, 16'd4,   1'b0, 7'd4 },
    {2'd2, 1'b0, 16'd7,   1'b1, 7'd1 },
    {2'd3, 1'b1, 16'd3,   1'b0, 7'd3 },
    {2'd3, 1'b0, 16'd2,   1'b0, 7'd2 },
    {2'd0, 1'b1, 16'd0,   1'b0, 7'd0 },
    {2'd0, 1'b1, 16'd64,  1'b0, 7'd64},
    {2'd1, 1'b0, 16'd300, 1'b0, 7'd16},
    {2'd3, 1'b1, 16'd1,   1'b1, 7'd7 },
    {2'd2, 1'b1, 16'd16,  1'b1, 7'd0 },
    {2'd0, 1'b0, 16'd33,  1'b0, 7'd32}
  };

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          in_valid = 1'b0;
  logic [1:0]    size_code = '0;
  logic          quad_sel = 1'b0;
  logic [CW-1:0] pred_count = '0;
  logic          pred_invert = 1'b0;
  logic [GW-1:0] src_a = '0;
  logic [GW-1:0] src_b = '0;
  logic          out_valid;
  logic [GW-1:0] dst;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  vsel_group #(.VLEN(VLEN), .CNT_W(CW)) u_dut (
    .clk, .rst_n, .in_valid, .size_code, .quad_sel, .pred_count,
    .pred_invert, .src_a, .src_b, .out_valid, .dst
  );

  function automatic logic [GW-1:0] model(input logic [GW-1:0] a,
      input logic [GW-1:0] b, input logic [1:0] sz, input logic q,
      input int cnt, input logic inv);
    logic [GW-1:0] res = '0;
    int eb = 1 << sz;
    int per = 16 / eb;
    int nr = q ? 4 : 2;
    for (int r = 0; r < nr; r++)
      for (int e = 0; e < per; e++) begin
        bit act = ((r * per + e) < cnt) != inv;
        for (int k = 0; k < eb; k++) begin
          int bp = r * 16 + e * eb + k;
          res[bp*8 +: 8] = act ? a[bp*8 +: 8] : b[bp*8 +: 8];
        end
      end
    return res;
  endfunction

  function automatic int count_from_a(input logic [GW-1:0] d,
      input logic [GW-1:0] a, input logic [1:0] sz, input logic q);
    int n = 0;
    int eb = 1 << sz;
    int per = 16 / eb;
    int nr = q ? 4 : 2;
    for (int r = 0; r < nr; r++)
      for (int e = 0; e < per; e++) begin
        bit same = 1'b1;
        for (int k = 0; k < eb; k++) begin
          int bp = r * 16 + e * eb + k;
          if (d[bp*8 +: 8] != a[bp*8 +: 8]) same = 1'b0;
        end
        if (same) n++;
      end
    return n;
  endfunction

  task automatic check(input bit ok, input string what,
                       input logic [GW-1:0] act, input logic [GW-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", what, act, exp);
    end
  endtask

  task automatic fill(input int seed);
    for (int k = 0; k < GW / 8; k++) begin
      src_a[k*8 +: 8] = 8'(seed * 37 + k * 5 + 1);
      src_b[k*8 +: 8] = ~src_a[k*8 +: 8];
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: run did not complete actual=hung expected=done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [GW-1:0] exp;
    logic [GW-1:0] held;
    repeat (3) @(negedge clk);
    // R8: state during reset
    check(out_valid == 1'b0, "R8 out_valid in reset", GW'(out_valid), '0);
    check(dst == '0, "R8 dst in reset", dst, '0);
    rst_n = 1'b1;
    @(negedge clk);
    check(out_valid == 1'b0, "R8 out_valid after release", GW'(out_valid), '0);

    for (int i = 0; i < NT; i++) begin
      logic [26:0] t = TBL[i];
      int got;
      fill(i);
      size_code   = t[26:25];
      quad_sel    = t[24];
      pred_count  = t[23:8];
      pred_invert = t[7];
      in_valid    = 1'b1;
      exp = model(src_a, src_b, t[26:25], t[24], int'(t[23:8]), t[7]);
      @(negedge clk);
      in_valid = 1'b0;
      check(out_valid == 1'b1, $sformatf("R7 valid strobe vector %0d", i),
            GW'(out_valid), GW'(1));
      check(dst == exp, $sformatf("R1 R3 R4 R5 R6 data vector %0d", i), dst, exp);
      got = count_from_a(dst, src_a, t[26:25], t[24]);
      check(got == int'(t[6:0]), $sformatf("R4 R5 R6 active count vector %0d", i),
            GW'(got), GW'(t[6:0]));
      if (!t[24])
        check(dst[GW-1:2*VLEN] == '0, $sformatf("R2 pair upper zero vector %0d", i),
              dst, '0);
    end

    // R7: idle cycles leave the result alone even with new inputs
    held = dst;
    fill(99);
    pred_count = 16'd9;
    quad_sel = 1'b1;
    @(negedge clk);
    check(out_valid == 1'b0, "R7 no strobe when idle", GW'(out_valid), '0);
    check(dst == held, "R7 dst held when idle", dst, held);

    // R2: quad after pair drives all four registers again
    fill(7);
    size_code = 2'd0; quad_sel = 1'b1; pred_count = 16'd40; pred_invert = 1'b0;
    in_valid = 1'b1;
    exp = model(src_a, src_b, 2'd0, 1'b1, 40, 1'b0);
    @(negedge clk);
    in_valid = 1'b0;
    check(dst == exp, "R2 quad group all registers", dst, exp);

    // R8: reset mid-run clears the output
    rst_n = 1'b0;
    @(negedge clk);
    check(dst == '0 && out_valid == 1'b0, "R8 reset clears output", dst, '0);
    rst_n = 1'b1;
    @(negedge clk);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule